// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is a single memory-to-memory copy channel that works through a chain of descriptors kept in memory. A start pulse hands it the address of the first descriptor. The channel reads that descriptor's ten words through a 32-bit read port. It then copies the frame the descriptor describes one word at a time, reading each word and then writing it. Each descriptor's packed control word decides whether the channel moves on to the descriptor whose address sits in the first word.

While it runs, the channel shows several values on its outputs: the bytes still to move in the current frame, the address of the descriptor it is fetching or last fetched, and an idle flag. Sticky status bits record block, frame, half-frame, last-frame and whole-chain events, each gated by the enables of the descriptor in force, and the OR of the status bits drives an interrupt line. A stop pulse abandons the chain at once.

Top module: `lldma_channel`

## Requirements
- R1: After reset the channel is idle: `idle_o` is 1, no read or write request is raised, `status_o` is 0 and `remain_o` is 0.
- R2: A start pulse while idle makes the channel read ten consecutive words at the head address, at offsets 0, 4, ... 36. A start pulse while busy is ignored and does not disturb the running chain.
- R3: Descriptor words are used by index: 0 next-descriptor address, 1 source, 2 destination, 3 frame length in bits [19:0], 7 control A, 8 control B. In control A, bit 30 is the link enable, bits [21:20] are the source mode and bits [23:22] are the destination mode. In control B, bits [22:18] are the event enables for block (18), chain done (19), frame (20), half-frame (21) and last-frame (22).
- R4: A frame of L bytes is moved as ceil(L/4) read-then-write pairs, in ascending word order, with the written data equal to the word read.
- R5: Address mode 0 keeps an address constant for the whole frame. Any other mode value advances the address by 4 after each word.
- R6: `remain_o` is loaded with the frame length and drops by 4 for each word written, stopping at 0.
- R7: At the end of a frame the channel fetches the descriptor at word 0 if the link enable is set. Otherwise it returns to idle. `next_desc_o` shows the address of the descriptor being or last fetched.
- R8: `status_o` uses bit 0 block, bit 1 chain done, bit 2 frame, bit 3 half-frame and bit 4 last-frame. Block and frame are set at every frame end. Chain done and last-frame are set when the chain ends. Half-frame is set on the write that first brings the remaining count to at most half the frame length. Each bit is set only if the current descriptor enables it. `irq_o` is the OR of the status bits.
- R9: A 1 in `irq_clr_i` clears that status bit. A set in the same cycle takes priority over the clear, and a bit that is not cleared stays set.
- R10: A stop pulse puts the channel in idle on the next cycle. After that no further request is raised and no chain-done status is set.
- R11: A descriptor with frame length 0 moves no data and goes straight to its link decision.
- R12: Read and write requests are never raised together. A raised request keeps its address (and, for writes, its data) until acknowledged, unless a stop intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| head_addr_i | input | AW | Address of the first descriptor, sampled with start |
| stop_i | input | 1 | Abort pulse |
| irq_clr_i | input | 5 | Write-1-to-clear mask for the status bits |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| remain_o | output | LEN_W | Bytes still to move in the current frame |
| next_desc_o | output | AW | Address of the descriptor being or last fetched |
| idle_o | output | 1 | High only when the channel is idle |
| status_o | output | 5 | Sticky event status bits |
| irq_o | output | 1 | OR of the status bits |

## Verification
Some properties are checked by assertions on every cycle: the two ports are exclusive, a raised request holds its address and data until acknowledged, idle means no request, a stop puts the channel in idle, the remaining count only falls on a write, and the status bits are sticky and write-1-to-clear. Other behaviour can only be shown by the bench scenarios, because it depends on what sits in memory: the order and contents of the copied words, constant versus incrementing addresses, the ten-word fetch, chain walking across a zero-length descriptor, the per-descriptor gating of status bits, the half-frame point, and the count left behind by an abort.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int DESC_WORDS = 10;
    localparam int NUM_EVT    = 5;

    // status / enable bit positions
    localparam int EV_BLOCK = 0;
    localparam int EV_CHAIN = 1;
    localparam int EV_FRAME = 2;
    localparam int EV_HALF  = 3;
    localparam int EV_LAST  = 4;

    // descriptor word indices
    localparam logic [3:0] WI_LINK = 4'd0;
    localparam logic [3:0] WI_SRC  = 4'd1;
    localparam logic [3:0] WI_DST  = 4'd2;
    localparam logic [3:0] WI_LEN  = 4'd3;
    localparam logic [3:0] WI_CTLA = 4'd7;
    localparam logic [3:0] WI_CTLB = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_LINK  = 3'd4
    } chan_st_e;

    typedef struct packed {
        logic                 link;
        logic [1:0]           src_mode;
        logic [1:0]           dst_mode;
        logic [NUM_EVT-1:0]   ien;
    } desc_ctl_t;

    // packed control A: link enable at 30, dst mode at [23:22], src mode at [21:20]
    function automatic desc_ctl_t ctl_from_a(input desc_ctl_t cur, input logic [31:0] w);
        desc_ctl_t c;
        c          = cur;
        c.link     = w[30];
        c.dst_mode = w[23:22];
        c.src_mode = w[21:20];
        return c;
    endfunction

    // packed control B: event enables at [22:18]
    function automatic desc_ctl_t ctl_from_b(input desc_ctl_t cur, input logic [31:0] w);
        desc_ctl_t c;
        c     = cur;
        c.ien = w[18 +: NUM_EVT];
        return c;
    endfunction

endpackage

// File: rtl/lldma_addr_step.sv
module lldma_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_comb begin
        if (mode_i == 2'd0) begin
            addr_o = addr_i;
        end else begin
            addr_o = addr_i + STEP_V;
        end
    end
endmodule

// File: rtl/lldma_status.sv
module lldma_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o,
    output logic         irq_o
);
    logic [N-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts_o = sts_q;
    assign irq_o = |sts_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R9: clear without a concurrent set empties the bit
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !sts_o[g]);
        // R9: a bit not cleared stays set
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_o[g] && !clr_i[g]) |=> sts_o[g]);
        // R9: set wins over clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> sts_o[g]);
    end
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [AW-1:0]      head_addr_i,
    input  logic               stop_i,
    input  logic [4:0]         irq_clr_i,
    output logic               rd_req_o,
    output logic [AW-1:0]      rd_addr_o,
    input  logic               rd_ack_i,
    input  logic [31:0]        rd_data_i,
    output logic               wr_req_o,
    output logic [AW-1:0]      wr_addr_o,
    output logic [31:0]        wr_data_o,
    input  logic               wr_ack_i,
    output logic [LEN_W-1:0]   remain_o,
    output logic [AW-1:0]      next_desc_o,
    output logic               idle_o,
    output logic [4:0]         status_o,
    output logic               irq_o
);
    localparam int            WORD_B   = 4;
    localparam logic [LEN_W-1:0] WORD_L = LEN_W'(WORD_B);
    localparam logic [3:0]    LAST_IDX = 4'(DESC_WORDS - 1);

    typedef struct packed {
        chan_st_e          st;
        logic [3:0]        widx;
        logic [AW-1:0]     desc;
        logic [AW-1:0]     link;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [LEN_W-1:0]  flen;
        logic [LEN_W-1:0]  remain;
        desc_ctl_t         ctl;
        logic [31:0]       data;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]      step_in  [2];
    logic [1:0]         step_md  [2];
    logic [AW-1:0]      step_out [2];
    logic [NUM_EVT-1:0] sts_set;
    logic [LEN_W-1:0]   rem_new;
    logic               half_now, half_before;

    assign step_in[0] = r_q.src;
    assign step_md[0] = r_q.ctl.src_mode;
    assign step_in[1] = r_q.dst;
    assign step_md[1] = r_q.ctl.dst_mode;

    for (genvar g = 0; g < 2; g++) begin : g_step
        lldma_addr_step #(.AW(AW), .STEP(WORD_B)) u_step (
            .addr_i (step_in[g]),
            .mode_i (step_md[g]),
            .addr_o (step_out[g])
        );
    end

    always_comb begin
        rem_new     = (r_q.remain > WORD_L) ? (r_q.remain - WORD_L) : '0;
        half_now    = ({rem_new, 1'b0} <= {1'b0, r_q.flen});
        half_before = ({r_q.remain, 1'b0} <= {1'b0, r_q.flen});
    end

    always_comb begin
        r_d       = r_q;
        sts_set   = '0;
        rd_req_o  = 1'b0;
        wr_req_o  = 1'b0;
        rd_addr_o = r_q.src;
        wr_addr_o = r_q.dst;
        wr_data_o = r_q.data;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.desc = head_addr_i;
                    r_d.widx = '0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                rd_req_o  = 1'b1;
                rd_addr_o = r_q.desc + (AW'(r_q.widx) << 2);
                if (rd_ack_i) begin
                    case (r_q.widx)
                        WI_LINK: r_d.link = rd_data_i[AW-1:0];
                        WI_SRC:  r_d.src  = rd_data_i[AW-1:0];
                        WI_DST:  r_d.dst  = rd_data_i[AW-1:0];
                        WI_LEN: begin
                            r_d.flen   = rd_data_i[LEN_W-1:0];
                            r_d.remain = rd_data_i[LEN_W-1:0];
                        end
                        WI_CTLA: r_d.ctl = ctl_from_a(r_q.ctl, rd_data_i);
                        WI_CTLB: r_d.ctl = ctl_from_b(r_q.ctl, rd_data_i);
                        default: ;
                    endcase
                    if (r_q.widx == LAST_IDX) begin
                        r_d.st = (r_q.flen == '0) ? ST_LINK : ST_RD;
                    end else begin
                        r_d.widx = r_q.widx + 4'd1;
                    end
                end
            end
            ST_RD: begin
                rd_req_o = 1'b1;
                if (rd_ack_i) begin
                    r_d.data = rd_data_i;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                wr_req_o = 1'b1;
                if (wr_ack_i) begin
                    r_d.src    = step_out[0];
                    r_d.dst    = step_out[1];
                    r_d.remain = rem_new;
                    sts_set[EV_HALF] = r_q.ctl.ien[EV_HALF] && half_now && !half_before;
                    r_d.st     = (rem_new == '0) ? ST_LINK : ST_RD;
                end
            end
            ST_LINK: begin
                sts_set[EV_BLOCK] = r_q.ctl.ien[EV_BLOCK];
                sts_set[EV_FRAME] = r_q.ctl.ien[EV_FRAME];
                if (r_q.ctl.link) begin
                    r_d.desc = r_q.link;
                    r_d.widx = '0;
                    r_d.st   = ST_FETCH;
                end else begin
                    sts_set[EV_CHAIN] = r_q.ctl.ien[EV_CHAIN];
                    sts_set[EV_LAST]  = r_q.ctl.ien[EV_LAST];
                    r_d.st            = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (stop_i) begin
            r_d.st  = ST_IDLE;
            sts_set = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    lldma_status #(.N(NUM_EVT)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (irq_clr_i),
        .sts_o (status_o),
        .irq_o (irq_o)
    );

    assign remain_o    = r_q.remain;
    assign next_desc_o = r_q.desc;
    assign idle_o      = (r_q.st == ST_IDLE);

    // R1: an idle channel raises no request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!rd_req_o && !wr_req_o));
    // R12: ports never used together
    a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));
    // R12: pending read holds its address
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i && !stop_i) |=> (rd_req_o && $stable(rd_addr_o)));
    // R12: pending write holds address and data
    a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i && !stop_i) |=>
            (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));
    // R10: stop returns to idle next cycle
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> idle_o);
    // R6: a completed write lowers the count or leaves it at zero
    a_r6_remain_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i && !stop_i) |=>
            ((remain_o < $past(remain_o)) || (remain_o == '0)));
    // R6: without a write and outside a fetch the count holds
    a_r6_remain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req_o && !rd_req_o) |=> $stable(remain_o));
endmodule

// File: tb/tb_lldma_channel.sv
`timescale 1ns/1ps
module tb_lldma_channel;
    localparam int AW = 32;
    localparam int LW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] head_addr_i = '0;
    logic          stop_i = 1'b0;
    logic [4:0]    irq_clr_i = '0;
    logic          rd_req_o, wr_req_o, wr_ack_i, rd_ack_i;
    logic [AW-1:0] rd_addr_o, wr_addr_o, next_desc_o;
    logic [31:0]   rd_data_i, wr_data_o;
    logic [LW-1:0] remain_o;
    logic          idle_o, irq_o;
    logic [4:0]    status_o;

    always #2.5 clk = ~clk;

    lldma_channel #(.AW(AW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_addr_i(head_addr_i),
        .stop_i(stop_i), .irq_clr_i(irq_clr_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .remain_o(remain_o), .next_desc_o(next_desc_o), .idle_o(idle_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [256];
    logic [63:0] exp_q [$];
    bit          sb_on = 1'b1;
    int          wcount = 0;
    int          rn = 0;
    logic [31:0] rlog [16];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // memory model with scoreboard monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack_i <= 1'b0;
            wr_ack_i <= 1'b0;
            rd_data_i <= '0;
        end else begin
            rd_ack_i <= rd_req_o && !rd_ack_i;
            wr_ack_i <= wr_req_o && !wr_ack_i;
            if (rd_req_o && !rd_ack_i) begin
                rd_data_i <= mem[rd_addr_o[9:2]];
                if (rn < 16) rlog[rn] = rd_addr_o;
                rn++;
            end
            if (wr_req_o && !wr_ack_i) begin
                mem[wr_addr_o[9:2]] = wr_data_o;
                wcount++;
                if (sb_on) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected write", wr_addr_o, 32'hFFFF_FFFF);
                    end else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        chk(wr_addr_o == e[63:32], "R5 write address", wr_addr_o, e[63:32]);
                        chk(wr_data_o == e[31:0], "R4 write data", wr_data_o, e[31:0]);
                    end
                end
            end
        end
    end

    // R3: descriptor layout written to memory
    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                            input logic [31:0] src, input logic [31:0] dst,
                            input int flen, input bit link, input logic [1:0] sm,
                            input logic [1:0] dm, input logic [4:0] ien);
        mem[base[9:2]+0] = nxt;
        mem[base[9:2]+1] = src;
        mem[base[9:2]+2] = dst;
        mem[base[9:2]+3] = 32'(flen) | 32'hFFF0_0000;
        mem[base[9:2]+4] = 32'd1;
        mem[base[9:2]+5] = 32'h0;
        mem[base[9:2]+6] = 32'h0;
        mem[base[9:2]+7] = (32'(link) << 30) | (32'(dm) << 22) | (32'(sm) << 20);
        mem[base[9:2]+8] = 32'(ien) << 18;
        mem[base[9:2]+9] = 32'hDEAD_0000;
    endtask

    // driver: push expected writes for one frame
    task automatic exp_frame(input logic [31:0] src, input logic [31:0] dst,
                             input int flen, input logic [1:0] sm, input logic [1:0] dm);
        for (int i = 0; i < (flen + 3) / 4; i++) begin
            logic [31:0] sa, da;
            sa = src + ((sm != 2'd0) ? 32'(4 * i) : 32'd0);
            da = dst + ((dm != 2'd0) ? 32'(4 * i) : 32'd0);
            exp_q.push_back({da, mem[sa[9:2]]});
        end
    endtask

    task automatic kick(input logic [31:0] head);
        rn = 0;
        @(negedge clk);
        start_i = 1'b1;
        head_addr_i = head;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (!idle_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk(1'b0, "watchdog", 32'(n), 32'd0);
    endtask

    task automatic clear_all();
        @(negedge clk);
        irq_clr_i = 5'h1F;
        @(negedge clk);
        irq_clr_i = 5'h0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h0101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(idle_o == 1'b1, "R1 idle", 32'(idle_o), 32'd1);
        chk(!rd_req_o && !wr_req_o, "R1 no request", {30'd0, rd_req_o, wr_req_o}, 32'd0);
        chk(status_o == 5'd0, "R1 status", 32'(status_o), 32'd0);
        chk(remain_o == '0, "R1 remain", 32'(remain_o), 32'd0);

        // single descriptor, incrementing both sides
        put_desc(32'h000, 32'h3F0, 32'h100, 32'h200, 12, 1'b0, 2'd1, 2'd1, 5'b10111);
        exp_frame(32'h100, 32'h200, 12, 2'd1, 2'd1);
        kick(32'h000);
        wait_idle();
        begin
            bit ok;
            ok = 1'b1;
            for (int i = 0; i < 10; i++) if (rlog[i] != 32'(4 * i)) ok = 1'b0;
            chk(ok, "R2 ten word fetch", rlog[9], 32'h24);
            chk(rlog[10] == 32'h100, "R3 source word", rlog[10], 32'h100);
        end
        chk(exp_q.size() == 0, "R4 all words moved", 32'(exp_q.size()), 32'd0);
        chk(status_o == 5'b10111, "R8 single status", 32'(status_o), 32'h17);
        chk(irq_o == 1'b1, "R8 irq", 32'(irq_o), 32'd1);
        chk(remain_o == '0, "R6 remain end", 32'(remain_o), 32'd0);
        chk(next_desc_o == 32'h000, "R7 no link followed", next_desc_o, 32'h0);
        @(negedge clk);
        irq_clr_i = 5'b00100;
        @(negedge clk);
        irq_clr_i = 5'b0;
        chk(status_o == 5'b10011, "R9 partial clear", 32'(status_o), 32'h13);
        clear_all();
        chk(status_o == 5'b0 && irq_o == 1'b0, "R9 full clear", 32'(status_o), 32'd0);

        // chain of three with zero-length middle and constant source
        put_desc(32'h040, 32'h080, 32'h100, 32'h200, 8, 1'b1, 2'd1, 2'd1, 5'b00100);
        put_desc(32'h080, 32'h0C0, 32'h180, 32'h280, 0, 1'b1, 2'd1, 2'd1, 5'b00000);
        put_desc(32'h0C0, 32'h3F0, 32'h140, 32'h240, 10, 1'b0, 2'd0, 2'd1, 5'b01010);
        exp_frame(32'h100, 32'h200, 8, 2'd1, 2'd1);
        exp_frame(32'h140, 32'h240, 10, 2'd0, 2'd1);
        kick(32'h040);
        repeat (6) @(negedge clk);
        // R2: start while busy must be ignored
        start_i = 1'b1;
        head_addr_i = 32'h000;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R11 R7 chain writes", 32'(exp_q.size()), 32'd0);
        chk(status_o == 5'b01110, "R8 chain status", 32'(status_o), 32'h0E);
        chk(next_desc_o == 32'h0C0, "R7 last descriptor", next_desc_o, 32'hC0);
        clear_all();

        // constant destination, no enables
        put_desc(32'h000, 32'h0, 32'h110, 32'h300, 6, 1'b0, 2'd1, 2'd0, 5'b00000);
        exp_frame(32'h110, 32'h300, 6, 2'd1, 2'd0);
        kick(32'h000);
        wait_idle();
        chk(exp_q.size() == 0, "R5 constant destination", 32'(exp_q.size()), 32'd0);
        chk(status_o == 5'b0 && irq_o == 1'b0, "R8 disabled events", 32'(status_o), 32'd0);
        chk(remain_o == '0, "R6 floor at zero", 32'(remain_o), 32'd0);

        // stop mid-frame
        sb_on = 1'b0;
        put_desc(32'h000, 32'h0, 32'h100, 32'h200, 40, 1'b0, 2'd1, 2'd1, 5'b10111);
        wcount = 0;
        kick(32'h000);
        while (wcount < 2) @(negedge clk);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(idle_o == 1'b1, "R10 idle after stop", 32'(idle_o), 32'd1);
        repeat (20) @(negedge clk);
        chk(wcount == 2, "R10 no writes after stop", 32'(wcount), 32'd2);
        chk(remain_o == LW'(32), "R6 count at stop", 32'(remain_o), 32'd32);
        chk(status_o[1] == 1'b0, "R10 no chain done", 32'(status_o), 32'd0);
        chk(!rd_req_o && !wr_req_o, "R10 quiet", {30'd0, rd_req_o, wr_req_o}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule